// File: doc/BRIEF.md
# HDLC Frame Serial Transmitter

This block turns bytes that a host writes into a bit-serial HDLC stream for the signaling channel of an E1 link. While enabled and with no frame pending, it sends the flag pattern 01111110 again and again. When the host loads a byte, the next flag boundary opens a frame. The payload follows with zero-bit insertion. The frame is closed by a 16-bit frame check sequence and a flag, and idle flags follow.

The host interface has two stages: a holding register and a shift stage. The host loads the next byte while the current one is being serialized. A ready flag requests that next byte. The host marks the final byte of a frame with a last flag written together with it. If the holding register is still empty when an open frame needs its next byte, the block sends an abort sequence and then returns to flags.

Every serial bit is gated by a grant pulse that stands for a bit position of the selected time slot. The output changes only after a grant and holds its value between grants.

Top module: `sig_hdlc_tx`

## Requirements
- R1: After reset, and whenever `enable_i` is low, `tx_o` is 1 and `ready_o` is 1. Pending bytes are discarded and the serializer restarts at the beginning of a flag.
- R2: While enabled with no byte loaded, the output is a continuous repetition of 0,1,1,1,1,1,1,0. The first bit after enabling is the leading 0 of a flag.
- R3: `tx_o` takes a new bit only in the clock cycle after a cycle in which `bit_en_i` is high. Otherwise it holds its value.
- R4: A write (`wr_i` high) while `ready_o` is low has no effect. The byte already held is neither replaced nor altered.
- R5: `ready_o` is high exactly when the holding stage is empty. It falls on the cycle after an accepted write. It rises when the held byte moves into the shift stage, which happens at a flag boundary or at the end of the previous payload byte.
- R6: A frame starts after a complete flag. Each payload byte is sent least significant bit first, and bytes go out in the order they were written.
- R7: Within payload and FCS, a 0 is inserted after every run of five consecutive 1s, including runs that cross byte boundaries. The inserted bit is not counted as data.
- R8: After the byte written with `wr_last_i`=1, the block sends 16 FCS bits: the ones' complement of the CRC (x^16+x^12+x^5+1, preset all ones, data taken LSB first), sent least significant bit first. A flag follows, and then idle flags.
- R9: If the holding stage is empty when a non-final payload byte finishes, the block sends the abort sequence 0 followed by seven 1s, then resumes flags.
- R10: Flags and abort sequences never carry inserted zeros, so six or seven consecutive 1s appear only in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Transmitter enable; low forces idle mark and clears state |
| bit_en_i | input | 1 | Time-slot bit grant; one serial bit per high cycle |
| wr_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | DATA_W | Payload byte |
| wr_last_i | input | 1 | Marks the written byte as the last of its frame |
| ready_o | output | 1 | Holding register empty; request for the next byte |
| tx_o | output | 1 | Serial HDLC output |

## Verification
The hardest situations to reach from the ports are a write that arrives while the holding stage is still full, and a stuffed zero that falls on a byte or FCS boundary. The bench pauses the grant pulses, so no byte transfer can free the register, and only then makes the second write. Afterwards it resumes the grants and measures how many bit grants pass before the ready flag returns. The payloads are chosen so that runs of ones cross byte edges, and an underrun is forced by simply stopping the writes in mid-frame. A bit-level receiver in the bench removes the stuffed zeros and recognises flags and aborts. It compares every frame it recovers against queued expectations.

// File: rtl/sig_hdlc_pkg.sv
package sig_hdlc_pkg;
  typedef enum logic [1:0] {
    U_FLAG  = 2'd0,
    U_DATA  = 2'd1,
    U_FCS   = 2'd2,
    U_ABORT = 2'd3
  } unit_e;

  localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE   = 8'hFE;  // LSB first: 0 then seven 1s
  localparam logic [15:0] CRC_POLY_RFL = 16'h8408;
  localparam int unsigned STUFF_RUN    = 5;
endpackage

// File: rtl/hdlc_byte_buffer.sv
module hdlc_byte_buffer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (flush_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
      last_q <= wr_last_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign last_o = last_q;

  assert_write_when_full_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i && !take_i && !flush_i) |=> ($stable(data_q) && $stable(last_q) && full_q));

  assert_take_frees_holding_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !flush_i) |=> !full_q);
endmodule

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16 #(
  parameter int unsigned      FCS_W = 16,
  parameter logic [FCS_W-1:0] POLY  = 16'h8408
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             upd_i,
  input  logic             bit_i,
  output logic [FCS_W-1:0] crc_next_o
);
  logic [FCS_W-1:0] crc_q;
  logic [FCS_W-1:0] shifted;

  // reflected form: data enters LSB first
  always_comb begin
    shifted = crc_q >> 1;
    if (crc_q[0] ^ bit_i) shifted = shifted ^ POLY;
    crc_next_o = upd_i ? shifted : crc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (upd_i)  crc_q <= shifted;
  end
endmodule

// File: rtl/sig_hdlc_tx.sv
module sig_hdlc_tx
  import sig_hdlc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FCS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              bit_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  output logic              ready_o,
  output logic              tx_o
);
  localparam int unsigned SH_W  = (FCS_W > DATA_W) ? FCS_W : DATA_W;
  localparam int unsigned CNT_W = $clog2(SH_W);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FCS_END  = CNT_W'(FCS_W - 1);
  localparam logic [CNT_W-1:0] OCT_END  = CNT_W'(7);

  unit_e             unit_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_q;
  logic [2:0]        ones_q;
  logic              stuff_q;
  logic              tx_q;

  logic              hold_full, hold_last, take;
  logic [DATA_W-1:0] hold_data;
  logic [FCS_W-1:0]  crc_next;
  logic              step, cur_bit, stuffable, unit_end, crc_init, crc_upd;
  logic [CNT_W-1:0]  end_cnt;
  logic [2:0]        ones_nx;

  assign step      = enable_i && bit_en_i;
  assign cur_bit   = sh_q[0];
  assign stuffable = (unit_q == U_DATA) || (unit_q == U_FCS);
  assign ones_nx   = cur_bit ? ones_q + 3'd1 : 3'd0;

  always_comb begin
    case (unit_q)
      U_DATA:  end_cnt = DATA_END;
      U_FCS:   end_cnt = FCS_END;
      default: end_cnt = OCT_END;
    endcase
  end

  assign unit_end = !stuff_q && (cnt_q == end_cnt);
  assign take     = step && unit_end && hold_full &&
                    ((unit_q == U_FLAG) || (unit_q == U_DATA && !last_q));
  assign crc_init = step && !stuffable;
  assign crc_upd  = step && !stuff_q && (unit_q == U_DATA);

  hdlc_byte_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (!enable_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .wr_last_i (wr_last_i),
    .take_i    (take),
    .full_o    (hold_full),
    .data_o    (hold_data),
    .last_o    (hold_last)
  );

  hdlc_fcs16 #(.FCS_W(FCS_W), .POLY(FCS_W'(CRC_POLY_RFL))) u_fcs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (crc_init),
    .upd_i      (crc_upd),
    .bit_i      (cur_bit),
    .crc_next_o (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q  <= U_FLAG;
      sh_q    <= SH_W'(FLAG_BYTE);
      cnt_q   <= '0;
      last_q  <= 1'b0;
      ones_q  <= '0;
      stuff_q <= 1'b0;
      tx_q    <= 1'b1;
    end else if (!enable_i) begin
      unit_q  <= U_FLAG;
      sh_q    <= SH_W'(FLAG_BYTE);
      cnt_q   <= '0;
      last_q  <= 1'b0;
      ones_q  <= '0;
      stuff_q <= 1'b0;
      tx_q    <= 1'b1;
    end else if (bit_en_i) begin
      if (stuff_q) begin
        tx_q    <= 1'b0;
        stuff_q <= 1'b0;
        ones_q  <= '0;
      end else begin
        tx_q <= cur_bit;
        if (stuffable) begin
          ones_q  <= ones_nx;
          stuff_q <= (ones_nx == 3'(STUFF_RUN));
        end else begin
          ones_q  <= '0;
        end
        if (!unit_end) begin
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          case (unit_q)
            U_FLAG: begin
              if (hold_full) begin
                unit_q <= U_DATA;
                sh_q   <= SH_W'(hold_data);
                last_q <= hold_last;
              end else begin
                sh_q   <= SH_W'(FLAG_BYTE);
              end
            end
            U_DATA: begin
              if (last_q) begin
                unit_q <= U_FCS;
                sh_q   <= SH_W'(~crc_next);
              end else if (hold_full) begin
                sh_q   <= SH_W'(hold_data);
                last_q <= hold_last;
              end else begin
                unit_q <= U_ABORT;
                sh_q   <= SH_W'(ABORT_BYTE);
              end
            end
            default: begin
              unit_q <= U_FLAG;
              sh_q   <= SH_W'(FLAG_BYTE);
            end
          endcase
        end
      end
    end
  end

  assign tx_o    = tx_q;
  assign ready_o = !hold_full;

  assert_idle_mark_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (tx_o && ready_o));

  assert_hold_between_grants_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !bit_en_i) |=> $stable(tx_o));

  assert_stuffed_bit_is_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && stuff_q) |=> !tx_o);

  assert_run_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 3'(STUFF_RUN));

  assert_abort_starts_with_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && unit_q == U_ABORT && cnt_q == '0 && !stuff_q) |=> !tx_o);
endmodule

// File: tb/sig_hdlc_tx_bench.sv
module sig_hdlc_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       bit_en = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_last = 1'b0;
  logic       ready, tx;

  always #2.5 clk = ~clk;  // 200 MHz

  sig_hdlc_tx u_sig_hdlc_tx (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .bit_en_i(bit_en),
    .wr_i(wr), .wr_data_i(wr_data), .wr_last_i(wr_last),
    .ready_o(ready), .tx_o(tx)
  );

  int checks = 0;
  int fails  = 0;

  // scoreboard: kind 0 = frame, 1 = abort
  int       exp_kind[$];
  int       exp_len[$];
  int       exp_req[$];
  bit [7:0] exp_data[$];

  bit grant_run = 0;
  bit mon_on    = 0;
  int gap       = 1;
  int grant_cnt = 0;
  int ones      = 0;
  int stuffs    = 0;
  int flags     = 0;
  bit rx_bits[$];
  bit log_bits[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit [15:0] crc_byte(input bit [15:0] c, input bit [7:0] b);
    bit [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      bit fb = r[0] ^ b[k];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic on_abort();
    if (exp_kind.size() == 0) begin
      chk(0, "R9 unexpected abort", 1, 0);
      return;
    end
    begin
      int k = exp_kind.pop_front();
      int r = exp_req.pop_front();
      int l = exp_len.pop_front();
      chk(k == 1, $sformatf("R%0d abort where frame expected", r), 1, k);
      for (int i = 0; i < l; i++) void'(exp_data.pop_front());
    end
  endtask

  task automatic on_flag();
    int n = rx_bits.size() - 7;
    flags++;
    if (n > 0) begin
      int nb = n / 8;
      bit [7:0] got[$];
      for (int i = 0; i < nb; i++) begin
        bit [7:0] b = '0;
        for (int k = 0; k < 8; k++) b[k] = rx_bits[i*8+k];
        got.push_back(b);
      end
      chk(n % 8 == 0, "R6 frame length in bits", n, nb * 8);
      if (exp_kind.size() == 0) begin
        chk(0, "R6 unexpected frame", nb, 0);
      end else begin
        int k = exp_kind.pop_front();
        int r = exp_req.pop_front();
        int l = exp_len.pop_front();
        bit [15:0] c = 16'hFFFF;
        chk(k == 0, $sformatf("R%0d frame where abort expected", r), 0, k);
        chk(nb == l + 2, $sformatf("R%0d frame byte count", r), nb, l + 2);
        for (int i = 0; i < l; i++) begin
          bit [7:0] e = exp_data.pop_front();
          c = crc_byte(c, e);
          if (i < nb) chk(got[i] == e, $sformatf("R%0d payload byte %0d", r, i), got[i], e);
        end
        c = ~c;
        if (nb == l + 2) // R8 FCS, low byte first
          chk({got[l+1], got[l]} == c, "R8 frame check sequence", {got[l+1], got[l]}, c);
      end
    end
    rx_bits.delete();
  endtask

  task automatic rx_bit(input bit b);
    log_bits.push_back(b);
    if (b) begin
      ones++;
      rx_bits.push_back(1'b1);
      if (ones == 7) begin
        on_abort();
        rx_bits.delete();
      end
    end else begin
      if (ones == 5) stuffs++;
      else if (ones == 6) on_flag();
      else if (ones >= 7) begin
        rx_bits.delete();
        rx_bits.push_back(1'b0);
      end else rx_bits.push_back(1'b0);
      ones = 0;
    end
  endtask

  // grant driver and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (grant_run) begin
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        grant_cnt++;
        if (mon_on) rx_bit(tx);
        repeat (gap) @(negedge clk);
      end
    end
  end

  task automatic push_frame(input bit [7:0] d[$], input int req);
    exp_kind.push_back(0);
    exp_len.push_back(d.size());
    exp_req.push_back(req);
    foreach (d[i]) exp_data.push_back(d[i]);
  endtask

  task automatic write_byte(input bit [7:0] d, input bit last);
    while (!ready) @(negedge clk);
    wr = 1'b1; wr_data = d; wr_last = last;
    @(negedge clk);
    wr = 1'b0; wr_last = 1'b0;
  endtask

  task automatic send_frame(input bit [7:0] d[$], input int req);
    push_frame(d, req);
    foreach (d[i]) write_byte(d[i], i == d.size() - 1);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_kind.size() > 0 && t < 30000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_kind.size() == 0, "R6 scoreboard drained", exp_kind.size(), 0);
  endtask

  task automatic pause();
    grant_run = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic restart();
    pause();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    ones = 0; rx_bits.delete(); log_bits.delete(); flags = 0; stuffs = 0;
    mon_on = 1;
    grant_run = 1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    bit [7:0] f[$];
    bit [7:0] prev;
    int g0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx == 1'b1, "R1 tx after reset", tx, 1);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    rst_n = 1'b1;
    grant_run = 1;
    repeat (30) @(negedge clk);
    chk(tx == 1'b1, "R1 tx while disabled with grants", tx, 1);
    chk(ready == 1'b1, "R1 ready while disabled", ready, 1);

    // R2 idle flags
    gap = 1;
    restart();
    while (grant_cnt < 60) @(negedge clk);
    begin
      bit [7:0] fl = '0;
      for (int k = 0; k < 8; k++) fl[k] = log_bits[k];
      chk(fl == 8'b0111_1110, "R2 first flag bits", fl, 8'h7E);
    end
    chk(flags >= 5, "R2 repeated flags", flags, 5);

    // R3 output holds without grants
    pause();
    prev = {7'd0, tx};
    repeat (25) @(negedge clk);
    chk(tx == prev[0], "R3 tx stable without grants", tx, prev[0]);
    grant_run = 1;

    // R6/R8 plain frame
    f = '{8'h12, 8'h34, 8'hA5, 8'h0F};
    send_frame(f, 6);
    drain();

    // R7 stuffing across byte edges, including into FCS
    gap = 3;
    stuffs = 0;
    f = '{8'hFF, 8'h7E, 8'hF8, 8'h1F, 8'hFF, 8'h3F};
    send_frame(f, 7);
    drain();
    chk(stuffs >= 4, "R7 stuffed zeros observed", stuffs, 4);

    // R4/R5 write while holding stage full, grants paused
    gap = 1;
    pause();
    chk(ready == 1'b1, "R5 ready before write", ready, 1);
    f = '{8'hC3};
    push_frame(f, 4);
    wr = 1'b1; wr_data = 8'hC3; wr_last = 1'b1;
    @(negedge clk);
    wr_data = 8'h99; wr_last = 1'b0;   // ignored: holding stage full
    @(negedge clk);
    wr = 1'b0;
    chk(ready == 1'b0, "R5 ready low after accepted write", ready, 0);
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "R4 ready still low after ignored write", ready, 0);
    g0 = grant_cnt;
    grant_run = 1;
    while (!ready && grant_cnt - g0 < 40) @(negedge clk);
    chk(ready == 1'b1 && grant_cnt - g0 <= 8, "R5 ready returns within one flag",
        grant_cnt - g0, 8);
    drain();

    // R9 underrun mid-frame
    exp_kind.push_back(1); exp_len.push_back(0); exp_req.push_back(9);
    write_byte(8'h81, 1'b0);
    write_byte(8'h42, 1'b0);
    drain();
    // R9/R10 recovery after abort: flags resume and a new frame decodes
    f = '{8'h55, 8'hAA};
    send_frame(f, 9);
    drain();

    // R1 disable clears a pending byte
    pause();
    write_byte(8'h66, 1'b1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 disable discards held byte", ready, 1);
    chk(tx == 1'b1, "R1 tx mark when disabled", tx, 1);
    mon_on = 0;

    finish_run();
  end
endmodule